// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer for a bus master that must prove its intent before it touches any control. It has four controls: reload the countdown, set the timeout count, switch the watchdog on or off, and set the clock divider. Each control sits behind its own guard word. A guard opens only after the right key values arrive at it in the right order. Its progress reads back in the two low bits of the guard word. The guard shuts again after one write to its control is accepted.

A divider splits the bus clock into ticks. A down-counter, loaded from the timeout count, counts those ticks. If software lets the counter run out while the watchdog is on, the block raises a single-cycle reset request. It then waits in an expired state until it is reloaded or switched off. The bus side is a plain single-cycle word port with a write strobe and a word index. Reads are combinational.

Top module: `keylock_watchdog`

## Requirements
- R1: After reset, every guard reads status 0, the on/off control reads 0, the timeout and divider read 0xFFFF, and the reset request is low.
- R2: Word index 0..7 holds, in this order: reload guard, reload, timeout guard, timeout, on/off guard, on/off, divider guard, divider. A guard reads its status in bits [1:0], with 0 above them. The reload word reads 0.
- R3: The reload, timeout and divider guards each open in two steps, and the status goes 0 → 1 → 3. The keys are 0x5555 then 0xAAAA for reload, 0x6666 then 0xBBBB for timeout, and 0x5A5A then 0xA5A5 for the divider. Keys are compared against the full 32-bit write data.
- R4: The on/off guard opens in three steps, and the status goes 0 → 1 → 2 → 3. The keys are 0x7777, then 0xCCCC, then 0xDDDD.
- R5: Any other value written to a guard returns its status to 0. The exception is the first key of that guard, which always sets the status to 1, from any state.
- R6: A write to a control while its guard is not at status 3 changes nothing, and the guard status stays as it was.
- R7: An accepted control write returns that guard to status 0.
- R8: The timeout and divider take the low 16 bits of the write data. A value of 0 is stored as 1.
- R9: Bit 0 of an accepted on/off write switches the watchdog on (1) or off (0). Switching it on reloads the countdown.
- R10: After a reload, the reset request rises exactly timeout × divider clock edges after the edge that accepts the reload.
- R11: The reset request lasts exactly one cycle, and it does not recur until the next reload. An accepted reload write with data other than 1 opens no reload: it only consumes the guard.
- R12: While the watchdog is off, the reset request stays low, and this holds even after a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe for this cycle |
| busAddr | input | 3 | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
The bench drives partial unlocks and then attempts control writes. If a design accepted such a write, or disturbed the guard, the stored value or the guard status would change. It sends keys in the wrong order and repeats the first key. A design that did not restart on the first key, or did not fall back to 0, would read the wrong status. The bench measures the edge count from a reload to the reset request over directed and random timeout and divider pairs. This exposes any off-by-one in the divider or the counter. It also checks that no second pulse appears after expiry, after a reload with data other than 1, or while the watchdog is off.

// File: rtl/gwd_pkg.sv
package gwd_pkg;
  localparam int unsigned LOCK_N = 4;

  // guard index = word index / 2
  localparam logic [1:0] LK_RELOAD   = 2'd0;
  localparam logic [1:0] LK_TIMEOUT  = 2'd1;
  localparam logic [1:0] LK_ONOFF    = 2'd2;
  localparam logic [1:0] LK_DIVIDER  = 2'd3;

  typedef struct packed {
    logic reload;
    logic setTimeout;
    logic setOnOff;
    logic setDivider;
  } wdgStrobe_t;
endpackage

// File: rtl/gwd_ctrl.sv
module gwd_ctrl
  import gwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWrite,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [LOCK_N-1:0][1:0]       lockSt,
  output wdgStrobe_t                   strobe
);
  localparam int unsigned KEY_W = 16;

  function automatic logic [KEY_W-1:0] keyOf(input int g, input int s);
    logic [KEY_W-1:0] k;
    k = '0;
    case (g)
      0: k = (s == 0) ? 16'h5555 : 16'hAAAA;
      1: k = (s == 0) ? 16'h6666 : 16'hBBBB;
      2: k = (s == 0) ? 16'h7777 : ((s == 1) ? 16'hCCCC : 16'hDDDD);
      default: k = (s == 0) ? 16'h5A5A : 16'hA5A5;
    endcase
    return k;
  endfunction

  logic [LOCK_N-1:0] accept;
  logic [ADDR_W-2:0] grp;
  assign grp = busAddr[ADDR_W-1:1];

  for (genvar g = 0; g < LOCK_N; g++) begin : gLock
    localparam logic [DATA_W-1:0] K0 = DATA_W'(keyOf(g, 0));
    localparam logic [DATA_W-1:0] K1 = DATA_W'(keyOf(g, 1));
    localparam logic [DATA_W-1:0] K2 = DATA_W'(keyOf(g, 2));
    localparam bit THREE_STEP = (g == 2);
    localparam logic [1:0] OPEN_FROM = THREE_STEP ? 2'd2 : 2'd1;

    logic lockWr, regWr;
    logic [1:0] nextSt;

    assign lockWr = busWrite && !busAddr[0] && (grp == (ADDR_W-1)'(g));
    assign regWr  = busWrite &&  busAddr[0] && (grp == (ADDR_W-1)'(g));
    assign accept[g] = regWr && (lockSt[g] == 2'd3);

    always_comb begin
      if (lockSt[g] == 2'd1 && busWdata == K1)
        nextSt = THREE_STEP ? 2'd2 : 2'd3;
      else if (THREE_STEP && lockSt[g] == 2'd2 && busWdata == K2)
        nextSt = 2'd3;
      else if (busWdata == K0)
        nextSt = 2'd1;
      else
        nextSt = 2'd0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)          lockSt[g] <= 2'd0;
      else if (lockWr)    lockSt[g] <= nextSt;
      else if (accept[g]) lockSt[g] <= 2'd0;
    end

    AST_ACCEPT_RELOCKS: assert property (@(posedge clk) disable iff (!rstN)
      accept[g] |=> lockSt[g] == 2'd0); // R7
    AST_IGNORED_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && lockSt[g] != 2'd3) |=> $stable(lockSt[g])); // R6
    AST_OPEN_PATH: assert property (@(posedge clk) disable iff (!rstN)
      (lockSt[g] == 2'd3 && $past(lockSt[g]) != 2'd3) |-> $past(lockSt[g]) == OPEN_FROM); // R4
  end

  assign strobe.reload     = accept[LK_RELOAD] && (busWdata == DATA_W'(1));
  assign strobe.setTimeout = accept[LK_TIMEOUT];
  assign strobe.setOnOff   = accept[LK_ONOFF];
  assign strobe.setDivider = accept[LK_DIVIDER];
endmodule

// File: rtl/gwd_datapath.sv
module gwd_datapath
  import gwd_pkg::*;
#(
  parameter int unsigned VAL_W = 16,
  parameter logic [VAL_W-1:0] RST_TIMEOUT = '1,
  parameter logic [VAL_W-1:0] RST_DIVIDER = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       strobe,
  input  logic [VAL_W-1:0] wrVal,
  input  logic             onBit,
  output logic [VAL_W-1:0] timeoutVal,
  output logic [VAL_W-1:0] dividerVal,
  output logic             enabled,
  output logic             resetReq
);
  logic [VAL_W-1:0] count, divCnt, clampVal;
  logic expired, doReload, tick;

  assign clampVal = (wrVal == '0) ? VAL_W'(1) : wrVal;
  assign doReload = strobe.reload || (strobe.setOnOff && onBit);
  assign tick     = divCnt >= (dividerVal - VAL_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutVal <= RST_TIMEOUT;
      dividerVal <= RST_DIVIDER;
      enabled    <= 1'b0;
      count      <= RST_TIMEOUT;
      divCnt     <= '0;
      expired    <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (strobe.setTimeout) timeoutVal <= clampVal;
      if (strobe.setDivider) dividerVal <= clampVal;
      if (strobe.setOnOff) begin
        enabled <= onBit;
        if (!onBit) expired <= 1'b0;
      end
      if (doReload) begin
        count   <= timeoutVal;
        divCnt  <= '0;
        expired <= 1'b0;
      end else if (enabled && !expired) begin
        if (tick) begin
          divCnt <= '0;
          if (count <= VAL_W'(1)) begin
            count    <= '0;
            expired  <= 1'b1;
            resetReq <= 1'b1;
          end else begin
            count <= count - VAL_W'(1);
          end
        end else begin
          divCnt <= divCnt + VAL_W'(1);
        end
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R11
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> !resetReq); // R12
  AST_VALUES_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    timeoutVal != '0 && dividerVal != '0); // R8
  AST_EXPIRE_FROM_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(count) == VAL_W'(1)); // R10
endmodule

// File: rtl/keylock_watchdog.sv
module keylock_watchdog
  import gwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned VAL_W  = 16,
  parameter logic [VAL_W-1:0] RST_TIMEOUT = '1,
  parameter logic [VAL_W-1:0] RST_DIVIDER = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              resetReq
);
  logic [LOCK_N-1:0][1:0] lockSt;
  wdgStrobe_t strobe;
  logic [VAL_W-1:0] timeoutVal, dividerVal;
  logic enabled;

  gwd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .lockSt(lockSt), .strobe(strobe)
  );

  gwd_datapath #(.VAL_W(VAL_W), .RST_TIMEOUT(RST_TIMEOUT), .RST_DIVIDER(RST_DIVIDER)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrVal(busWdata[VAL_W-1:0]),
    .onBit(busWdata[0]), .timeoutVal(timeoutVal), .dividerVal(dividerVal),
    .enabled(enabled), .resetReq(resetReq)
  );

  always_comb begin
    busRdata = '0;
    if (!busAddr[0]) busRdata = DATA_W'(lockSt[busAddr[ADDR_W-1:1]]);
    else begin
      case (busAddr[ADDR_W-1:1])
        LK_TIMEOUT[ADDR_W-2:0]: busRdata = DATA_W'(timeoutVal);
        LK_ONOFF[ADDR_W-2:0]:   busRdata = DATA_W'(enabled);
        LK_DIVIDER[ADDR_W-2:0]: busRdata = DATA_W'(dividerVal);
        default:                busRdata = '0;
      endcase
    end
  end
endmodule

// File: tb/keylock_watchdog_test.sv
module keylock_watchdog_test;
  logic clk = 0, rstN = 0, busWrite = 0;
  logic [2:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic resetReq;
  int checks = 0, failures = 0;
  int modelSt[4];

  always #4 clk = ~clk;

  keylock_watchdog uut (.clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .resetReq(resetReq));

  function automatic logic [31:0] key(input int g, input int s);
    case (g)
      0: return (s == 0) ? 32'h5555 : 32'hAAAA;
      1: return (s == 0) ? 32'h6666 : 32'hBBBB;
      2: return (s == 0) ? 32'h7777 : ((s == 1) ? 32'hCCCC : 32'hDDDD);
      default: return (s == 0) ? 32'h5A5A : 32'hA5A5;
    endcase
  endfunction

  function automatic int nextLock(input int g, input int st, input logic [31:0] d);
    if (st == 1 && d == key(g, 1)) return (g == 2) ? 2 : 3;
    if (g == 2 && st == 2 && d == key(g, 2)) return 3;
    if (d == key(g, 0)) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1; busAddr = 3'(a); busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWrite = 0;
  endtask

  task automatic rdChk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = 3'(a);
    #1 check(tag, busRdata, exp);
  endtask

  task automatic openLock(input int g);
    wr(2*g, key(g, 0));
    wr(2*g, key(g, 1));
    if (g == 2) wr(2*g, key(g, 2));
  endtask

  task automatic prog(input int g, input logic [31:0] v);
    openLock(g);
    wr(2*g + 1, v);
  endtask

  // call right after the write accepting a reload; counts edges to the pulse
  task automatic measure(input string tag, input int exp);
    int n = 0, seen = 0;
    for (int i = 1; i <= exp + 40 && seen == 0; i++) begin
      @(posedge clk); #1;
      if (resetReq) begin n = i; seen = 1; end
    end
    check(tag, 32'(n), 32'(exp));
    @(posedge clk); #1;
    check({tag, " single"}, {31'b0, resetReq}, 32'd0);
  endtask

  task automatic quiet(input string tag, input int cyc);
    int hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      if (resetReq) hits++;
    end
    check(tag, 32'(hits), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog timeout act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R1 / R2 reset state and map
    for (int g = 0; g < 4; g++) rdChk("R1 guard", 2*g, 32'd0);
    rdChk("R2 reload word", 1, 32'd0);
    rdChk("R1 timeout", 3, 32'hFFFF);
    rdChk("R1 onoff", 5, 32'd0);
    rdChk("R1 divider", 7, 32'hFFFF);
    check("R1 resetReq", {31'b0, resetReq}, 32'd0);

    // R3 two-step sequences
    wr(0, 32'h5555); rdChk("R3 reload step1", 0, 1);
    wr(0, 32'hAAAA); rdChk("R3 reload step2", 0, 3);
    wr(2, 32'h6666); rdChk("R3 timeout step1", 2, 1);
    wr(2, 32'hBBBB); rdChk("R3 timeout step2", 2, 3);
    wr(3, 32'd3);    rdChk("R3 timeout stored", 3, 3);
    rdChk("R7 timeout relocked", 2, 0);
    wr(6, 32'h5A5A); rdChk("R3 divider step1", 6, 1);
    wr(6, 32'hA5A5); rdChk("R3 divider step2", 6, 3);
    wr(7, 32'd2);    rdChk("R3 divider stored", 7, 2);
    rdChk("R7 divider relocked", 6, 0);
    wr(1, 32'd1);    rdChk("R7 reload relocked", 0, 0);

    // R4 three-step, R6 write on partial unlock
    wr(4, 32'h7777); rdChk("R4 onoff step1", 4, 1);
    wr(4, 32'hCCCC); rdChk("R4 onoff step2", 4, 2);
    wr(5, 32'd1);    rdChk("R6 onoff ignored", 5, 0);
    rdChk("R6 guard kept", 4, 2);
    wr(4, 32'hDDDD); rdChk("R4 onoff step3", 4, 3);
    wr(5, 32'd1);
    measure("R10 enable 3x2", 6);
    rdChk("R9 enabled", 5, 1);
    rdChk("R7 onoff relocked", 4, 0);
    quiet("R11 no repeat after expiry", 30);

    // R11 reload with other data
    prog(0, 32'd2);
    quiet("R11 data!=1 no reload", 20);
    rdChk("R11 guard consumed", 0, 0);
    openLock(0); wr(1, 32'd1);
    measure("R10 reload 3x2", 6);

    // R5 wrong and out-of-order keys
    wr(0, 32'h5555); wr(0, 32'h1234); rdChk("R5 wrong key", 0, 0);
    wr(0, 32'hAAAA); rdChk("R5 out of order", 0, 0);
    wr(0, 32'h5555); wr(0, 32'h5555); rdChk("R5 first key restarts", 0, 1);
    wr(0, 32'h0001_5555); rdChk("R5 full width compare", 0, 0);
    wr(4, 32'h7777); wr(4, 32'hCCCC); wr(4, 32'hCCCC); rdChk("R5 onoff repeat", 4, 0);

    // R8 clamp and truncation
    prog(1, 32'd0);           rdChk("R8 timeout zero", 3, 1);
    prog(1, 32'hABCD_0004);   rdChk("R8 timeout low bits", 3, 4);
    prog(3, 32'd0);           rdChk("R8 divider zero", 7, 1);
    openLock(0); wr(1, 32'd1);
    measure("R10 divider 1", 4);

    // R12 disabled stays silent
    prog(2, 32'd0); rdChk("R9 disabled", 5, 0);
    openLock(0); wr(1, 32'd1);
    quiet("R12 off after reload", 40);

    // R10 random timeout/divider pairs
    for (int it = 0; it < 30; it++) begin
      int c = 1 + int'($urandom % 6);
      int p = 1 + int'($urandom % 5);
      prog(1, 32'(c));
      prog(3, 32'(p));
      openLock(2); wr(5, 32'd1);
      measure("R10 random period", c * p);
      prog(2, 32'd0);
    end

    // R5 random guard traffic
    for (int g = 0; g < 4; g++) modelSt[g] = 0;
    for (int it = 0; it < 150; it++) begin
      int g = int'($urandom % 4);
      int pick = int'($urandom % 4);
      logic [31:0] d = (pick == 3) ? $urandom : key(g, pick);
      modelSt[g] = nextLock(g, modelSt[g], d);
      wr(2*g, d);
      rdChk("R5 random guard", 2*g, 32'(modelSt[g]));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule